// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from on-chip peripheral sources and from external pins, picks the single most urgent one, and presents it to a processor core as a vector number and a vector address. The core accepts the presented vector by raising an acknowledge input. The controller keeps one global interrupt-enable bit. Acceptance clears this bit, a return-from-interrupt strobe sets it again, and separate set and clear strobes let software change it directly. A handler that sets the bit again allows nested interrupts.

External lines pass through a two-flop synchronizer. Each line has its own enable bit and a two-bit trigger field that selects low level, falling edge, rising edge or off. An edge is held in a per-line pending flag until that vector is accepted. A level request exists only while the synchronized pin is low. Internal sources are level requests gated only by the global enable. A reset request owns vector 0 and ignores every enable. The vector table can sit at any base address, with one 4-byte slot per vector.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset is released, `irq` is 1 with `vec_num` 0 while `gie` is 0. This reset request ignores the global enable. Once vector 0 has been accepted, it does not come back until the next reset.
- R2: Vector numbering is fixed: 0 is reset, external line k is vector k+1, and internal source j is vector N_EXT+1+j. When several vectors request, the lowest number is presented.
- R3: `vec_addr` equals `vec_base + 4*vec_num`, truncated to ADDR_W bits.
- R4: An accept is a rising edge with `irq` and `irq_ack` both 1. It clears `gie` at that edge, even if `gie_set` or `reti` is high in the same cycle.
- R5: When no accept occurs, `gie_clr` clears `gie`, and `gie_set` or `reti` sets it. If both kinds of strobe are high together, the clear wins. `gie` is 0 after reset.
- R6: Internal source j requests exactly when `int_req[j]` and `gie` are both 1.
- R7: An external line requests only when its `ext_en` bit and `gie` are both 1.
- R8: `ext_mode[2k+1:2k]` sets line k's trigger: 00 low level, 01 falling edge, 10 rising edge, 11 off. In mode 11 the line never requests, whatever the pin does.
- R9: In low-level mode a line requests while its synchronized pin is low. The request appears at the second rising edge after the pin falls and goes away at the second rising edge after the pin rises. Nothing is latched.
- R10: In an edge mode, the selected edge sets a pending flag at the third rising edge after the pin changes. The flag is set even while the line or `gie` is disabled, and it stays set until that vector is accepted.
- R11: Accepting an edge line's vector clears its pending flag. An edge detected in the accept cycle leaves the flag set.
- R12: While `gie` is 0, only the reset vector can raise `irq`. Setting `gie` inside a handler lets the next request be accepted (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | N_INT | Internal peripheral request levels |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| ext_en | input | N_EXT | Per-line enables for the external lines |
| ext_mode | input | 2*N_EXT | Per-line trigger fields, two bits per line |
| vec_base | input | ADDR_W | Base address of the vector table |
| irq_ack | input | 1 | Core accepts the presented vector |
| gie_set | input | 1 | Sets the global enable |
| gie_clr | input | 1 | Clears the global enable |
| reti | input | 1 | Return-from-interrupt strobe, sets the global enable |
| irq | output | 1 | A vector is being presented |
| vec_num | output | VN_W | Number of the presented vector |
| vec_addr | output | ADDR_W | Address of the presented vector slot |
| gie | output | 1 | Current global enable |

## Verification
The hardest case to reach from the ports is an edge that arrives in the same cycle in which the same vector is accepted. Its pending flag must then survive the accept. The stimulus reaches it by toggling a rising-edge pin twice in quick succession, counting the synchronizer delay so that the second detected edge lines up with the acknowledge. It then confirms that the vector returns once `reti` restores the enable. A second hard case is a nested accept: the bench sets the enable inside a handler while a lower-priority source waits. Long stretches of random pins, modes, strobes and acknowledges are then compared every cycle against a behavioural reference model.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_OFF  = 2'b11
  } trig_mode_e;

  // slot address: base plus four bytes per vector
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [31:0] num);
    return base + (num << 2);
  endfunction

  function automatic int ext_vec(input int line);
    return 1 + line;
  endfunction

  function automatic int int_vec(input int n_ext, input int src);
    return 1 + n_ext + src;
  endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // pins idle high, so reset to 1 to avoid a false low level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/intc_ext_line.sv
module intc_ext_line
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  trig_mode_e mode,
  input  logic       en,
  input  logic       gie,
  input  logic       acc_this,
  output logic       req,
  output logic       pend
);
  logic prev_q;
  logic pend_q;
  logic rise_w;
  logic fall_w;
  logic hit_w;
  logic edge_mode_w;
  logic raw_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign rise_w      = pin_s & ~prev_q;
  assign fall_w      = ~pin_s & prev_q;
  assign edge_mode_w = (mode == TRIG_RISE) || (mode == TRIG_FALL);
  assign hit_w       = ((mode == TRIG_RISE) && rise_w) ||
                       ((mode == TRIG_FALL) && fall_w);

  // a new edge outranks the clear caused by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (!edge_mode_w) pend_q <= 1'b0;
    else if (hit_w)        pend_q <= 1'b1;
    else if (acc_this)     pend_q <= 1'b0;
  end

  always_comb begin
    unique case (mode)
      TRIG_LOW:             raw_w = ~pin_s;
      TRIG_FALL, TRIG_RISE: raw_w = pend_q;
      default:              raw_w = 1'b0;
    endcase
  end

  assign req  = raw_w & en & gie;
  assign pend = pend_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  // scanning downward leaves the lowest active index in idx
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_gie.sv
module intc_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic set_s,
  input  logic clr_s,
  input  logic ret_s,
  output logic gie
);
  logic gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gie_q <= 1'b0;
    else if (accept)         gie_q <= 1'b0;
    else if (clr_s)          gie_q <= 1'b0;
    else if (set_s || ret_s) gie_q <= 1'b1;
  end

  assign gie = gie_q;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int N_INT  = 6,
  parameter int ADDR_W = 16,
  localparam int NVEC  = 1 + N_EXT + N_INT,
  localparam int VN_W  = $clog2(NVEC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_INT-1:0]     int_req,
  input  logic [N_EXT-1:0]     ext_pin,
  input  logic [N_EXT-1:0]     ext_en,
  input  logic [2*N_EXT-1:0]   ext_mode,
  input  logic [ADDR_W-1:0]    vec_base,
  input  logic                 irq_ack,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 reti,
  output logic                 irq,
  output logic [VN_W-1:0]      vec_num,
  output logic [ADDR_W-1:0]    vec_addr,
  output logic                 gie
);
  // named internal events, also observed by the bound checker
  logic             accept;
  logic             rst_pend;
  logic [N_EXT-1:0] pin_s;
  logic [N_EXT-1:0] ext_req;
  logic [N_EXT-1:0] ext_pend;
  logic [NVEC-1:0]  req_all;
  logic             win_any;
  logic [VN_W-1:0]  win_idx;

  intc_sync #(.W(N_EXT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_pin),
    .q_sync  (pin_s)
  );

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    logic acc_k;
    assign acc_k = accept && (vec_num == VN_W'(ext_vec(k)));
    intc_ext_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[k]),
      .mode     (trig_mode_e'(ext_mode[2*k +: 2])),
      .en       (ext_en[k]),
      .gie      (gie),
      .acc_this (acc_k),
      .req      (ext_req[k]),
      .pend     (ext_pend[k])
    );
    assign req_all[ext_vec(k)] = ext_req[k];
  end

  for (genvar j = 0; j < N_INT; j++) begin : g_int
    assign req_all[int_vec(N_EXT, j)] = int_req[j] & gie;
  end

  // reset request: pending from reset until vector 0 is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rst_pend <= 1'b1;
    else if (accept && vec_num == '0)  rst_pend <= 1'b0;
  end
  assign req_all[0] = rst_pend;

  intc_prio #(.N(NVEC), .W(VN_W)) u_prio (
    .req (req_all),
    .any (win_any),
    .idx (win_idx)
  );

  assign irq      = win_any;
  assign vec_num  = win_idx;
  assign vec_addr = ADDR_W'(slot_addr(32'(vec_base), 32'(win_idx)));
  assign accept   = win_any & irq_ack;

  intc_gie u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .set_s  (gie_set),
    .clr_s  (gie_clr),
    .ret_s  (reti),
    .gie    (gie)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_EXT = 4,
  parameter int VN_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               irq_ack,
  input logic [VN_W-1:0]    vec_num,
  input logic               gie,
  input logic               gie_set,
  input logic               gie_clr,
  input logic               reti,
  input logic               rst_pend,
  input logic [N_EXT-1:0]   ext_pend,
  input logic [2*N_EXT-1:0] ext_mode
);
  // R1: the reset request is presented as vector 0
  p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> (irq && vec_num == '0));

  // R1: the reset request does not return once accepted
  p_reset_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pend |=> !rst_pend);

  // R4: acceptance clears the global enable
  p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> !gie);

  // R5: clear strobe outranks set strobes
  p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr && !(irq && irq_ack)) |=> !gie);

  // R5: set or return strobe sets the enable
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !(irq && irq_ack)) |=> gie);

  // R12: with the enable off only reset may request
  p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !rst_pend) |-> !irq);

  for (genvar k = 0; k < N_EXT; k++) begin : g_pend
    // R11: a pending edge drops only on its accept or a leave from edge mode
    p_pend_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_pend[k]) |->
        ($past(irq && irq_ack && vec_num == VN_W'(k + 1)) ||
         $past(ext_mode[2*k +: 2] == 2'b00 || ext_mode[2*k +: 2] == 2'b11)));
  end
endmodule

bind prio_vec_intc intc_chk #(.N_EXT(N_EXT), .VN_W(VN_W)) u_intc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .irq_ack  (irq_ack),
  .vec_num  (vec_num),
  .gie      (gie),
  .gie_set  (gie_set),
  .gie_clr  (gie_clr),
  .reti     (reti),
  .rst_pend (rst_pend),
  .ext_pend (ext_pend),
  .ext_mode (ext_mode)
);

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  localparam int CLK_P  = 10;
  localparam int N_EXT  = 4;
  localparam int N_INT  = 6;
  localparam int ADDR_W = 16;
  localparam int VN_W   = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [N_INT-1:0]    int_req = '0;
  logic [N_EXT-1:0]    ext_pin = '1;
  logic [N_EXT-1:0]    ext_en = '0;
  logic [2*N_EXT-1:0]  ext_mode = '1;
  logic [ADDR_W-1:0]   vec_base = 16'h0100;
  logic                irq_ack = 1'b0;
  logic                gie_set = 1'b0;
  logic                gie_clr = 1'b0;
  logic                reti = 1'b0;
  logic                irq;
  logic [VN_W-1:0]     vec_num;
  logic [ADDR_W-1:0]   vec_addr;
  logic                gie;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_vec_intc #(.N_EXT(N_EXT), .N_INT(N_INT), .ADDR_W(ADDR_W)) i_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_pin(ext_pin),
    .ext_en(ext_en), .ext_mode(ext_mode), .vec_base(vec_base),
    .irq_ack(irq_ack), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .irq(irq), .vec_num(vec_num), .vec_addr(vec_addr), .gie(gie)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1[N_EXT];
  int m_s2[N_EXT];
  int m_prev[N_EXT];
  bit m_pend[N_EXT];
  bit m_gie;
  bit m_rp;

  function automatic void predict(output bit irq_e, output int num_e);
    irq_e = 0;
    num_e = 0;
    if (m_rp) begin
      irq_e = 1;
      return;
    end
    if (!m_gie) return;
    for (int k = 0; k < N_EXT; k++) begin
      int md;
      bit lv;
      md = int'(ext_mode[2*k +: 2]);
      if (md == 0)                lv = (m_s2[k] == 0);
      else if (md == 1 || md == 2) lv = m_pend[k];
      else                        lv = 0;
      if (ext_en[k] && lv) begin
        irq_e = 1;
        num_e = k + 1;
        return;
      end
    end
    for (int j = 0; j < N_INT; j++) begin
      if (int_req[j]) begin
        irq_e = 1;
        num_e = 1 + N_EXT + j;
        return;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0;
      m_rp = 1;
      for (int k = 0; k < N_EXT; k++) begin
        m_s1[k] = 1; m_s2[k] = 1; m_prev[k] = 1; m_pend[k] = 0;
      end
    end else begin
      bit pi;
      int pn;
      bit acc;
      predict(pi, pn);
      acc = pi && irq_ack;
      if (acc)                   m_gie = 0;
      else if (gie_clr)          m_gie = 0;
      else if (gie_set || reti)  m_gie = 1;
      if (acc && pn == 0) m_rp = 0;
      for (int k = 0; k < N_EXT; k++) begin
        int md;
        bit rise, fall;
        md = int'(ext_mode[2*k +: 2]);
        rise = (m_s2[k] == 1) && (m_prev[k] == 0);
        fall = (m_s2[k] == 0) && (m_prev[k] == 1);
        if (md == 0 || md == 3)                      m_pend[k] = 0;
        else if ((md == 2 && rise) || (md == 1 && fall)) m_pend[k] = 1;
        else if (acc && pn == k + 1)                 m_pend[k] = 0;
        m_prev[k] = m_s2[k];
        m_s2[k] = m_s1[k];
        m_s1[k] = int'(ext_pin[k]);
      end
    end
  end

  // compare on every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && !done) begin
      bit pi;
      int pn;
      predict(pi, pn);
      chk("R12 model irq", 32'(irq), 32'(pi));
      chk("R5 model gie", 32'(gie), 32'(m_gie));
      if (pi) begin
        chk("R2 model vec_num", 32'(vec_num), 32'(pn));
        chk("R3 model vec_addr", 32'(vec_addr), 32'(ADDR_W'(32'(vec_base) + 32'(pn) * 4)));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept_one();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 irq after reset", 32'(irq), 1);
    chk("R1 vec_num after reset", 32'(vec_num), 0);
    chk("R3 reset slot addr", 32'(vec_addr), 32'h100);
    chk("R5 gie after reset", 32'(gie), 0);

    int_req[2] = 1'b1;
    step(1);
    chk("R1 reset over masked internal", 32'(vec_num), 0);
    accept_one();
    chk("R6 internal masked by gie", 32'(irq), 0);
    step(2);
    chk("R1 reset not repeated", 32'(irq), 0);

    gie_set = 1'b1; step(1); gie_set = 1'b0;
    chk("R5 set strobe", 32'(gie), 1);
    chk("R6 internal request", 32'(irq), 1);
    chk("R6 internal vector", 32'(vec_num), 7);
    chk("R3 internal addr", 32'(vec_addr), 32'h11C);

    int_req[0] = 1'b1; step(1);
    chk("R2 lower internal wins", 32'(vec_num), 5);

    irq_ack = 1'b1; gie_set = 1'b1; step(1); irq_ack = 1'b0; gie_set = 1'b0;
    chk("R4 accept beats set", 32'(gie), 0);
    chk("R4 no irq after accept", 32'(irq), 0);

    int_req = '0;
    gie_set = 1'b1; gie_clr = 1'b1; step(1); gie_set = 1'b0; gie_clr = 1'b0;
    chk("R5 clear beats set", 32'(gie), 0);
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R5 return sets", 32'(gie), 1);

    // level line 1 (vector 2)
    ext_mode[3:2] = 2'b00; ext_en = 4'b0010;
    ext_pin[1] = 1'b0;
    step(1);
    chk("R9 level not yet seen", 32'(irq), 0);
    step(1);
    chk("R9 level request", 32'(irq), 1);
    chk("R9 level vector", 32'(vec_num), 2);
    chk("R3 level addr", 32'(vec_addr), 32'h108);
    ext_en[1] = 1'b0; step(1);
    chk("R7 line enable gates", 32'(irq), 0);
    ext_en[1] = 1'b1; ext_pin[1] = 1'b1; step(1);
    chk("R9 level still synced low", 32'(irq), 1);
    step(1);
    chk("R9 level released", 32'(irq), 0);

    // rising line 2 (vector 3), latched while disabled
    ext_mode[5:4] = 2'b10;
    ext_pin[2] = 1'b0; step(3);
    ext_pin[2] = 1'b1; step(3);
    chk("R10 disabled line quiet", 32'(irq), 0);
    ext_en[2] = 1'b1; step(1);
    chk("R10 pending kept", 32'(irq), 1);
    chk("R10 rising vector", 32'(vec_num), 3);
    accept_one();
    chk("R4 gie cleared", 32'(gie), 0);
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R11 pending cleared by accept", 32'(irq), 0);

    // falling line 3 (vector 4) against internal 1 (vector 6), nesting
    ext_mode[7:6] = 2'b01; ext_en[3] = 1'b1; int_req[1] = 1'b1;
    step(1);
    chk("R6 internal vector 6", 32'(vec_num), 6);
    ext_pin[3] = 1'b0; step(3);
    chk("R2 external over internal", 32'(vec_num), 4);
    accept_one();
    chk("R12 masked in handler", 32'(irq), 0);
    gie_set = 1'b1; step(1); gie_set = 1'b0;
    chk("R12 nested request", 32'(irq), 1);
    chk("R12 nested vector", 32'(vec_num), 6);
    accept_one();
    int_req = '0;
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R12 nothing left", 32'(irq), 0);

    // mode off on line 0
    ext_pin[3] = 1'b1;
    ext_en[0] = 1'b1;
    ext_pin[0] = 1'b0; step(3);
    ext_pin[0] = 1'b1; step(3);
    chk("R8 off mode quiet", 32'(irq), 0);

    // edge arriving in the accept cycle of the same vector
    ext_pin[2] = 1'b0; step(3);
    ext_pin[2] = 1'b1; step(1);
    ext_pin[2] = 1'b0; step(1);
    ext_pin[2] = 1'b1; step(1);
    step(1);
    chk("R10 first edge pending", 32'(vec_num), 3);
    accept_one();
    chk("R4 gie off after accept", 32'(gie), 0);
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R11 edge in accept cycle kept", 32'(irq), 1);
    chk("R11 kept vector", 32'(vec_num), 3);
    accept_one();
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R11 second accept clears", 32'(irq), 0);

    // relocated base with wrap
    vec_base = 16'hFFF8; int_req[5] = 1'b1; step(1);
    chk("R3 relocated wrap addr", 32'(vec_addr), 32'h0020);
    int_req = '0;

    // random phase, with a reset in the middle
    for (int c = 0; c < 3000; c++) begin
      int_req  = ($urandom % 4 == 0) ? N_INT'($urandom) : '0;
      irq_ack  = ($urandom % 3 == 0);
      gie_set  = ($urandom % 8 == 0);
      gie_clr  = ($urandom % 10 == 0);
      reti     = ($urandom % 8 == 0);
      if ($urandom % 3 == 0) ext_pin = N_EXT'($urandom);
      if (c % 16 == 0) ext_en = N_EXT'($urandom);
      if (c % 64 == 0) ext_mode = (2*N_EXT)'($urandom);
      if (c % 256 == 0) vec_base = ADDR_W'($urandom);
      if (c == 1500) rst_n = 1'b0;
      if (c == 1503) rst_n = 1'b1;
      step(1);
    end
    irq_ack = 1'b0; gie_set = 1'b0; gie_clr = 1'b0; reti = 1'b0;
    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule